// File: doc/BRIEF.md
# Pipelined Nth-Packet Sampler

This block marks one packet out of every ten (by default) for sampling as headers stream through a switch pipeline. Each clock it accepts at most one packet header: a valid bit, a 32-bit source address and a tag that the block does not interpret. Two cycles later the same packet comes out, with a sample field added. The sample field holds the source address on every tenth valid packet and zero on all others.

The work is split into two stages. The first stage holds the only persistent state, a packet counter. In one clock it reads the counter, compares the value with the last count of the period and writes back either zero or the value plus one. It hands the compare result forward with the packet as metadata. The second stage keeps no state. It uses that carried flag to choose between the source address and zero for the sample field.

Because the counter update completes within a single cycle, packets that arrive on consecutive clocks each see the count left by the packet before them. No increment is lost, whatever the spacing of the traffic.

Top module: `nth_sampler_pipe`

## Requirements
- R1: After reset the output valid is low, the sample field is 0 and the counter is 0. The first nine valid packets therefore carry sample 0 and the tenth carries its source address.
- R2: A valid packet that finds the stored count equal to the parameter LAST_COUNT (default 9) leaves with sample equal to its source address, and the count becomes 0.
- R3: A valid packet that finds any other count leaves with sample 0, and the count rises by one.
- R4: A cycle with the input valid low leaves the counter unchanged. Two cycles later it produces an output with valid low and sample 0.
- R5: A valid packet appears at the output exactly two clock cycles after it is presented, with its source address and tag unchanged.
- R6: Valid packets on consecutive clocks are each counted once. With continuous traffic, every tenth packet is sampled.
- R7: Asserting the synchronous reset in the middle of traffic clears the counter and empties both pipeline stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A packet header is present this cycle |
| in_src | input | ADDR_W (32) | Source address of the packet |
| in_tag | input | TAG_W (8) | Pass-through tag |
| out_valid | output | 1 | A processed packet is present |
| out_src | output | ADDR_W (32) | Source address, delayed two cycles |
| out_tag | output | TAG_W (8) | Tag, delayed two cycles |
| out_sample | output | ADDR_W (32) | Sample field: the source address or 0 |

## Verification
The hardest cases to reach are the counter wrap while packets arrive on consecutive clocks, and the wrap when idle cycles fall in the middle of a period. Either case would expose a lost or a doubled increment. The stimulus table interleaves gaps with bursts, so that the tenth valid packet lands after several idle cycles. Long unbroken runs follow, which place two wraps back to back in continuous traffic. A reset issued partway through a period then checks that counting starts again from zero.

// File: rtl/nth_sampler_pkg.sv
package nth_sampler_pkg;
  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_TAG_W      = 8;
  localparam int DEF_LAST_COUNT = 9;

  function automatic int count_width(input int last);
    return (last < 1) ? 1 : $clog2(last + 1);
  endfunction
endpackage

// File: rtl/sampler_count_stage.sv
module sampler_count_stage #(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 8,
  parameter int LAST_COUNT = 9,
  localparam int CNT_W     = nth_sampler_pkg::count_width(LAST_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              s1_valid,
  output logic [ADDR_W-1:0] s1_src,
  output logic [TAG_W-1:0]  s1_tag,
  output logic              s1_hit,
  output logic [CNT_W-1:0]  s1_old
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_COUNT);

  logic [CNT_W-1:0] count_q;
  logic             hit_now;
  logic [CNT_W-1:0] count_next;

  // Read, compare and write back happen in one cycle so that the next packet
  // always sees the updated count.
  always_comb begin
    hit_now    = (count_q == LAST_C);
    count_next = count_q;
    if (in_valid) count_next = hit_now ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      s1_valid <= 1'b0;
      s1_src   <= '0;
      s1_tag   <= '0;
      s1_hit   <= 1'b0;
      s1_old   <= '0;
    end else begin
      count_q  <= count_next;
      s1_valid <= in_valid;
      s1_src   <= in_src;
      s1_tag   <= in_tag;
      s1_hit   <= in_valid & hit_now;
      s1_old   <= count_q;
    end
  end

  // R4: an idle cycle leaves the counter alone
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> count_q == $past(count_q));
  // R2: a valid packet at the last count wraps the counter
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count_q == LAST_C) |=> count_q == '0);
  // R3: any other valid packet advances the counter by one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count_q != LAST_C) |=> count_q == $past(count_q) + 1'b1);
  // R1: the counter never leaves the period range
  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST_C);
endmodule

// File: rtl/sampler_select_stage.sv
module sampler_select_stage #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [ADDR_W-1:0] s1_src,
  input  logic [TAG_W-1:0]  s1_tag,
  input  logic              s1_hit,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_src,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ADDR_W-1:0] out_sample
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_src    <= '0;
      out_tag    <= '0;
      out_sample <= '0;
    end else begin
      out_valid  <= s1_valid;
      out_src    <= s1_src;
      out_tag    <= s1_tag;
      out_sample <= (s1_valid && s1_hit) ? s1_src : '0;
    end
  end

  // R5: valid moves forward one cycle in this stage
  a_r5_valid_follow: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  // R4: an idle slot gives a quiet output
  a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> (!out_valid && out_sample == '0));
  // R2: a flagged packet carries its source address as the sample
  a_r2_sample: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_hit) |=> out_sample == $past(s1_src));
  // R3: an unflagged packet carries a zero sample
  a_r3_zero: assert property (@(posedge clk) disable iff (rst)
    !s1_hit |=> out_sample == '0);
endmodule

// File: rtl/nth_sampler_pipe.sv
module nth_sampler_pipe #(
  parameter int ADDR_W     = nth_sampler_pkg::DEF_ADDR_W,
  parameter int TAG_W      = nth_sampler_pkg::DEF_TAG_W,
  parameter int LAST_COUNT = nth_sampler_pkg::DEF_LAST_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_src,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ADDR_W-1:0] out_sample
);
  localparam int CNT_W = nth_sampler_pkg::count_width(LAST_COUNT);

  logic              s1_valid;
  logic [ADDR_W-1:0] s1_src;
  logic [TAG_W-1:0]  s1_tag;
  logic              s1_hit;
  logic [CNT_W-1:0]  s1_old;

  sampler_count_stage #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .LAST_COUNT(LAST_COUNT)
  ) u_count (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_src(in_src), .in_tag(in_tag),
    .s1_valid(s1_valid), .s1_src(s1_src), .s1_tag(s1_tag),
    .s1_hit(s1_hit), .s1_old(s1_old)
  );

  sampler_select_stage #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) u_select (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_src(s1_src), .s1_tag(s1_tag), .s1_hit(s1_hit),
    .out_valid(out_valid), .out_src(out_src), .out_tag(out_tag),
    .out_sample(out_sample)
  );

  // R2: the carried old count agrees with the flag it travels with
  a_r2_meta: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_hit) |-> s1_old == CNT_W'(LAST_COUNT));
endmodule

// File: tb/nth_sampler_pipe_test.sv
`timescale 1ns/1ps
module nth_sampler_pipe_test;
  localparam int LAST = 9;
  localparam int NV   = 16;
  // each entry: {valid, expected hit, source address}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h0A00_0001}, {1'b1, 1'b0, 32'h0A00_0002},
    {1'b0, 1'b0, 32'hDEAD_BEEF}, {1'b1, 1'b0, 32'h0A00_0004},
    {1'b1, 1'b0, 32'h0A00_0005}, {1'b1, 1'b0, 32'h0A00_0006},
    {1'b1, 1'b0, 32'h0A00_0007}, {1'b0, 1'b0, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 32'h1234_5678}, {1'b1, 1'b0, 32'h0A00_000A},
    {1'b1, 1'b0, 32'h0A00_000B}, {1'b1, 1'b0, 32'h0A00_000C},
    {1'b1, 1'b1, 32'hC0A8_0105}, {1'b1, 1'b0, 32'h0A00_000E},
    {1'b1, 1'b0, 32'h0A00_000F}, {1'b1, 1'b0, 32'h0A00_0010}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_src = '0;
  logic [7:0] in_tag = '0;
  logic out_valid;
  logic [31:0] out_src, out_sample;
  logic [7:0] out_tag;

  int checks = 0;
  int failures = 0;
  int mc = 0;
  logic e1_v = 0, e2_v = 0;
  logic [31:0] e1_src = 0, e2_src = 0, e1_smp = 0, e2_smp = 0;
  logic [7:0] e1_tag = 0, e2_tag = 0;

  always #2 clk = ~clk;

  nth_sampler_pipe #(.ADDR_W(32), .TAG_W(8), .LAST_COUNT(LAST)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_tag(in_tag),
    .out_valid(out_valid), .out_src(out_src), .out_tag(out_tag),
    .out_sample(out_sample)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge: check the packet driven two calls earlier, then drive
  task automatic step(input logic v, input logic [31:0] src, input logic [7:0] tag,
                      input string req);
    logic hit;
    chk({req, " R5 valid"}, {31'b0, out_valid}, {31'b0, e2_v});
    if (e2_v) begin
      chk({req, " sample"}, out_sample, e2_smp);
      chk({req, " R5 src"}, out_src, e2_src);
      chk({req, " R5 tag"}, {24'b0, out_tag}, {24'b0, e2_tag});
    end else begin
      chk({req, " R4 idle sample"}, out_sample, 32'h0);
    end
    hit = 1'b0;
    if (v) begin
      hit = (mc == LAST);
      mc  = hit ? 0 : mc + 1;
    end
    e2_v = e1_v; e2_src = e1_src; e2_tag = e1_tag; e2_smp = e1_smp;
    e1_v = v; e1_src = src; e1_tag = tag; e1_smp = hit ? src : 32'h0;
    in_valid = v; in_src = src; in_tag = tag;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mc = 0; e1_v = 0; e2_v = 0; e1_smp = 0; e2_smp = 0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: quiet outputs straight after reset
    chk("R1 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R1 reset sample", out_sample, 32'h0);

    // table walk: idle gaps inside the first period, tenth valid packet sampled (R1, R2, R3, R4)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33] && (VEC[i][32] != (mc == LAST)))
        chk("R1 table hit position", {31'b0, VEC[i][32]}, {31'b0, mc == LAST});
      step(VEC[i][33], VEC[i][31:0], 8'(i), "R1 R2 R3 table");
    end

    // R6: long back-to-back run, two wraps in continuous traffic
    for (int i = 0; i < 25; i++) step(1'b1, 32'hAC10_0000 + 32'(i), 8'(8'h40 + i), "R6 burst");

    // R4: a run of idle cycles, then traffic resumes where the count stood
    for (int i = 0; i < 4; i++) step(1'b0, 32'h5555_5555, 8'hEE, "R4 idle");
    for (int i = 0; i < 12; i++) step(1'b1, 32'hB000_0000 + 32'(i), 8'(8'h80 + i), "R4 resume");

    // R7: reset partway through a period
    for (int i = 0; i < 5; i++) step(1'b1, 32'hD000_0000 + 32'(i), 8'(i), "R7 pre");
    do_reset();
    chk("R7 reset valid", {31'b0, out_valid}, 32'h0);
    for (int i = 0; i < 12; i++) step(1'b1, 32'hE000_0000 + 32'(i), 8'(8'hC0 + i), "R7 restart");
    // flush
    for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 8'h0, "R5 flush");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule